// File: doc/BRIEF.md
# Sticky Fault Status Capture Register

This unit sits beside a memory subsystem's error detectors and keeps a software-visible record of the faults they report. Each fault type has its own strobe. All strobes share one payload: the faulting address, a 9-bit data ECC syndrome, a 4-bit tag ECC syndrome, the index of the 16-byte beat within a 64-byte bus transfer, and the processor privilege state. A detected fault sets a sticky status bit for its type. That bit stays set until software writes a 1 to it on the register write port. Reading the status word has no side effect.

There is one address register, one data-syndrome field and one tag-syndrome field. Each of them is held by the most important outstanding event. Faults are ranked in three classes: uncorrectable first, then software-correctable, then hardware-corrected. When two events of the same class arrive in the same cycle, the lower type index wins. A held field is replaced only by an event of a strictly higher class. It is released as soon as the status bit of its own event is cleared. A multiple-error flag records repeats of uncorrectable and software-correctable faults. An error pin and a disrupting-trap request, gated by an interrupt enable, are also produced.

Top module: `fault_status_log`

## Requirements
- R1: After reset the status word, the captured address, both syndrome fields, the error pin and the trap request are all zero.
- R2: A strobe on type i sets status bit i on the next clock edge. A register write clears exactly those bits of the status word (bits 7:0 are fault types, bit 8 is the multiple-error flag, bit 9 is the privilege bit) that are 1 in the written data. Written 0 bits leave their bits unchanged.
- R3: When a clear of bit i and a new accepted strobe on type i arrive in the same cycle, bit i stays set. The multiple-error flag is not set, and the captured fields keep their current owner.
- R4: The multiple-error flag (bit 8) sets when an uncorrectable or software-correctable fault arrives while its status bit is already set. A repeated hardware-corrected fault never sets it.
- R5: A strobe whose beat index is greater than that of the last accepted strobe belongs to the same transfer and is ignored: no status bit and no flag changes. A beat index equal to or less than that of the last accepted strobe starts a new transfer.
- R6: Type classes are: types 0, 1, 2 and 3 uncorrectable; types 4 and 5 software-correctable; types 6 and 7 hardware-corrected. A held address is overwritten only by a strictly higher class. In a same-class tie within one cycle, the lowest type index wins.
- R7: A held field is released when its owner's status bit is cleared, even if other status bits remain set. It keeps its value until the next capture.
- R8: The data syndrome field captures only from types 0, 2, 4 and 6. The tag syndrome field captures only from types 3, 5 and 7. Each field has its own lock, governed by the same rules as the address.
- R9: The privilege bit (bit 9) takes the strobe's privilege value whenever the address is captured. Otherwise it is unchanged.
- R10: The error pin is high while status bit 0 (protocol error) or bit 1 (internal error) is set.
- R11: The trap request is high exactly while the interrupt enable is high and at least one of status bits 2 to 7 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_strobe | input | 8 | One strobe per fault type |
| ev_addr | input | 32 | Faulting address |
| ev_dsyn | input | 9 | Data ECC syndrome |
| ev_tsyn | input | 4 | Tag ECC syndrome |
| ev_beat | input | 2 | 16-byte beat index within the 64-byte transfer |
| ev_priv | input | 1 | Privilege state at detection |
| wr_en | input | 1 | Register write strobe (write-one-to-clear) |
| wr_data | input | 10 | Bits to clear |
| irq_en | input | 1 | Interrupt enable for the trap request |
| status_o | output | 10 | Status word: types, multiple-error flag, privilege |
| addr_o | output | 32 | Captured address |
| dsyn_o | output | 9 | Captured data syndrome |
| tsyn_o | output | 4 | Captured tag syndrome |
| err_pin_o | output | 1 | External error pin |
| trap_req_o | output | 1 | Disrupting-trap request |

## Verification
The bench drives single strobes, repeated strobes of each class, and simultaneous same-class strobes. The repeats separate the multiple-error rule for corrected faults from the rule for uncorrectable ones. The simultaneous pair shows which index wins a tie. Clears are interleaved with captures, so the tests can tell a release caused by the owner's own bit from one caused by any other bit. Faults of lower class than the held owner are sent first before release and again after it. A clear lands in the same cycle as a new fault on that bit. Beat sequences that rise and then restart separate suppressed beats from new transfers. The three capture fields run under their own locks, and mixed data and tag types show that these locks are independent.

// File: rtl/fault_log_pkg.sv
package fault_log_pkg;

  // Capture rank of a fault class; larger wins, 0 means no candidate.
  function automatic logic [1:0] rank_f(input logic is_ue, input logic is_swc);
    if (is_ue)       return 2'd3;
    else if (is_swc) return 2'd2;
    else             return 2'd1;
  endfunction

  // Repeat rule for the multiple-error flag.
  function automatic logic counts_repeat(input logic is_ue, input logic is_swc);
    return is_ue | is_swc;
  endfunction

endpackage

// File: rtl/fault_beat_filter.sv
module fault_beat_filter #(
  parameter int N      = 8,
  parameter int BEAT_W = 2,
  parameter bit EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      strobe_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [N-1:0]      acc_o,
  output logic              suppress_o
);

  generate
    if (EN) begin : g_filter
      logic              txn_act_q;
      logic [BEAT_W-1:0] txn_beat_q;
      logic              any_strobe;

      assign any_strobe = |strobe_i;
      // A later beat than the last accepted one belongs to the same transfer.
      assign suppress_o = txn_act_q && (beat_i > txn_beat_q);
      assign acc_o      = suppress_o ? '0 : strobe_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          txn_act_q  <= 1'b0;
          txn_beat_q <= '0;
        end else if (any_strobe && !suppress_o) begin
          txn_act_q  <= 1'b1;
          txn_beat_q <= beat_i;
        end
      end

      AST_SUPPRESS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress_o && |strobe_i) |=> $stable(txn_beat_q)); // R5
    end else begin : g_pass
      assign suppress_o = 1'b0;
      assign acc_o      = strobe_i;
    end
  endgenerate

endmodule

// File: rtl/fault_capture_slot.sv
module fault_capture_slot
  import fault_log_pkg::*;
#(
  parameter int           N        = 8,
  parameter int           W        = 32,
  parameter logic [N-1:0] ELIG     = '1,
  parameter logic [N-1:0] UE_MASK  = '0,
  parameter logic [N-1:0] SWC_MASK = '0,
  localparam int          IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] acc_i,
  input  logic [N-1:0] clr_eff_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] held_o,
  output logic         cap_o
);

  logic [IDX_W-1:0] owner_q;
  logic [1:0]       owner_rank_q;
  logic             owner_vld_q;
  logic [IDX_W-1:0] cand_idx;
  logic [1:0]       cand_rank;
  logic             still_locked;

  // Highest class wins; strict compare keeps the lowest index on a tie.
  always_comb begin
    cand_idx  = '0;
    cand_rank = 2'd0;
    for (int i = 0; i < N; i++) begin
      if (acc_i[i] && ELIG[i] && (rank_f(UE_MASK[i], SWC_MASK[i]) > cand_rank)) begin
        cand_rank = rank_f(UE_MASK[i], SWC_MASK[i]);
        cand_idx  = IDX_W'(i);
      end
    end
  end

  assign still_locked = owner_vld_q && !clr_eff_i[owner_q];
  assign cap_o        = (cand_rank != 2'd0) && (!still_locked || (cand_rank > owner_rank_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q      <= '0;
      owner_rank_q <= 2'd0;
      owner_vld_q  <= 1'b0;
      held_o       <= '0;
    end else if (cap_o) begin
      owner_q      <= cand_idx;
      owner_rank_q <= cand_rank;
      owner_vld_q  <= 1'b1;
      held_o       <= data_i;
    end else if (!still_locked) begin
      owner_vld_q  <= 1'b0;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (still_locked && !cap_o) |=> $stable(held_o)); // R7

  AST_SLOT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_i & ELIG) == '0) |-> !cap_o); // R8

endmodule

// File: rtl/fault_status_log.sv
module fault_status_log
  import fault_log_pkg::*;
#(
  parameter int           N          = 8,
  parameter int           ADDR_W     = 32,
  parameter int           DSYN_W     = 9,
  parameter int           TSYN_W     = 4,
  parameter int           TXN_BYTES  = 64,
  parameter int           SUB_BYTES  = 16,
  parameter bit           FILTER_EN  = 1'b1,
  parameter logic [N-1:0] UE_MASK    = 8'b0000_1111,
  parameter logic [N-1:0] SWC_MASK   = 8'b0011_0000,
  parameter logic [N-1:0] DSYN_MASK  = 8'b0101_0101,
  parameter logic [N-1:0] TSYN_MASK  = 8'b1010_1000,
  parameter logic [N-1:0] PIN_MASK   = 8'b0000_0011,
  parameter logic [N-1:0] TRAP_MASK  = 8'b1111_1100,
  localparam int          BEAT_W     = $clog2(TXN_BYTES / SUB_BYTES),
  localparam int          SW         = N + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      ev_strobe,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DSYN_W-1:0] ev_dsyn,
  input  logic [TSYN_W-1:0] ev_tsyn,
  input  logic [BEAT_W-1:0] ev_beat,
  input  logic              ev_priv,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_data,
  input  logic              irq_en,
  output logic [SW-1:0]     status_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DSYN_W-1:0] dsyn_o,
  output logic [TSYN_W-1:0] tsyn_o,
  output logic              err_pin_o,
  output logic              trap_req_o
);

  localparam int MULTI_BIT = N;
  localparam int PRIV_BIT  = N + 1;

  logic [N-1:0] acc;
  logic         suppress;
  logic [N-1:0] clr;
  logic [N-1:0] clr_eff;
  logic [N-1:0] repeat_hit;
  logic [N-1:0] sticky_q;
  logic         multi_q;
  logic         priv_q;
  logic         addr_cap;
  logic         dsyn_cap;
  logic         tsyn_cap;

  fault_beat_filter #(.N(N), .BEAT_W(BEAT_W), .EN(FILTER_EN)) u_filter (
    .clk(clk), .rst_n(rst_n), .strobe_i(ev_strobe), .beat_i(ev_beat),
    .acc_o(acc), .suppress_o(suppress)
  );

  assign clr     = wr_en ? wr_data[N-1:0] : '0;
  assign clr_eff = clr & ~acc;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      repeat_hit[i] = acc[i] && sticky_q[i] && !clr[i] &&
                      counts_repeat(UE_MASK[i], SWC_MASK[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      multi_q  <= 1'b0;
      priv_q   <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr) | acc;
      multi_q  <= (|repeat_hit) | (multi_q & !(wr_en && wr_data[MULTI_BIT]));
      if (addr_cap)                      priv_q <= ev_priv;
      else if (wr_en && wr_data[PRIV_BIT]) priv_q <= 1'b0;
    end
  end

  fault_capture_slot #(.N(N), .W(ADDR_W), .ELIG({N{1'b1}}),
                       .UE_MASK(UE_MASK), .SWC_MASK(SWC_MASK)) u_addr_slot (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .clr_eff_i(clr_eff),
    .data_i(ev_addr), .held_o(addr_o), .cap_o(addr_cap)
  );

  fault_capture_slot #(.N(N), .W(DSYN_W), .ELIG(DSYN_MASK),
                       .UE_MASK(UE_MASK), .SWC_MASK(SWC_MASK)) u_dsyn_slot (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .clr_eff_i(clr_eff),
    .data_i(ev_dsyn), .held_o(dsyn_o), .cap_o(dsyn_cap)
  );

  fault_capture_slot #(.N(N), .W(TSYN_W), .ELIG(TSYN_MASK),
                       .UE_MASK(UE_MASK), .SWC_MASK(SWC_MASK)) u_tsyn_slot (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .clr_eff_i(clr_eff),
    .data_i(ev_tsyn), .held_o(tsyn_o), .cap_o(tsyn_cap)
  );

  assign status_o   = {priv_q, multi_q, sticky_q};
  assign err_pin_o  = |(sticky_q & PIN_MASK);
  assign trap_req_o = irq_en && (|(sticky_q & TRAP_MASK));

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sticky_q) & ~sticky_q)) |-> $past(wr_en)); // R2

  AST_SET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~$past(sticky_q) & sticky_q)) |-> $past(|ev_strobe)); // R2

  AST_SUPPRESSED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (suppress && !wr_en) |=> (sticky_q == $past(sticky_q))); // R5

  AST_MULTI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(multi_q) |-> $past(|(ev_strobe & (UE_MASK | SWC_MASK)))); // R4

  AST_ADDR_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_o) |-> $past(|acc)); // R6

  AST_PIN_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pin_o) |-> $past(|(ev_strobe & PIN_MASK))); // R10

  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !trap_req_o); // R11

  AST_SYN_CAP_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dsyn_cap || tsyn_cap) |-> (|acc)); // R8

endmodule

// File: tb/fault_status_log_bench.sv
`timescale 1ns/1ps
module fault_status_log_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ev_strobe = '0;
  logic [31:0] ev_addr = '0;
  logic [8:0]  ev_dsyn = '0;
  logic [3:0]  ev_tsyn = '0;
  logic [1:0]  ev_beat = '0;
  logic        ev_priv = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_data = '0;
  logic        irq_en = 1'b0;
  logic [9:0]  status_o;
  logic [31:0] addr_o;
  logic [8:0]  dsyn_o;
  logic [3:0]  tsyn_o;
  logic        err_pin_o;
  logic        trap_req_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_status_log u_fault_status_log (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_addr(ev_addr),
    .ev_dsyn(ev_dsyn), .ev_tsyn(ev_tsyn), .ev_beat(ev_beat), .ev_priv(ev_priv),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .status_o(status_o),
    .addr_o(addr_o), .dsyn_o(dsyn_o), .tsyn_o(tsyn_o), .err_pin_o(err_pin_o),
    .trap_req_o(trap_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; one-cycle strobe, returns at the next negedge.
  task automatic fire(input logic [7:0] m, input logic [31:0] a, input logic [8:0] d,
                      input logic [3:0] t, input logic [1:0] b, input logic p);
    ev_strobe = m; ev_addr = a; ev_dsyn = d; ev_tsyn = t; ev_beat = b; ev_priv = p;
    @(negedge clk);
    ev_strobe = '0; ev_beat = '0;
  endtask

  task automatic clear(input logic [9:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status_o), 32'h0);
    chk("R1 addr", addr_o, 32'h0);
    chk("R1 dsyn", 32'(dsyn_o), 32'h0);
    chk("R1 tsyn", 32'(tsyn_o), 32'h0);
    chk("R1 pin", 32'(err_pin_o), 32'h0);
    chk("R1 trap", 32'(trap_req_o), 32'h0);
  endtask

  task automatic t_first_capture();
    fire(8'h40, 32'hA1, 9'h1A1, 4'h3, 2'd0, 1'b1);
    chk("R2 sticky set", 32'(status_o), 32'h240);
    chk("R6 addr first", addr_o, 32'hA1);
    chk("R8 dsyn type6", 32'(dsyn_o), 32'h1A1);
    chk("R8 tsyn not eligible", 32'(tsyn_o), 32'h0);
    chk("R11 trap gated off", 32'(trap_req_o), 32'h0);
    irq_en = 1'b1; #1;
    chk("R11 trap on", 32'(trap_req_o), 32'h1);
    @(negedge clk);
    fire(8'h40, 32'hA2, 9'h002, 4'h0, 2'd0, 1'b0);
    chk("R4 hw-corrected repeat no flag", 32'(status_o), 32'h240);
    chk("R6 same class keeps addr", addr_o, 32'hA1);
    chk("R9 priv unchanged without capture", 32'(status_o[9]), 32'h1);
  endtask

  task automatic t_overwrite();
    fire(8'h04, 32'hA3, 9'h055, 4'h0, 2'd0, 1'b0);
    chk("R6 higher class overwrites", addr_o, 32'hA3);
    chk("R8 dsyn overwritten", 32'(dsyn_o), 32'h055);
    chk("R9 priv follows capture", 32'(status_o), 32'h044);
    fire(8'h10, 32'hA4, 9'h033, 4'h0, 2'd0, 1'b1);
    chk("R6 lower class ignored", addr_o, 32'hA3);
    chk("R9 status after lower", 32'(status_o), 32'h054);
  endtask

  task automatic t_unlock();
    clear(10'h004);
    chk("R2 selective clear", 32'(status_o), 32'h050);
    chk("R7 value kept after release", addr_o, 32'hA3);
    fire(8'h40, 32'hA5, 9'h0F0, 4'h0, 2'd0, 1'b1);
    chk("R7 capture after release", addr_o, 32'hA5);
    chk("R7 dsyn after release", 32'(dsyn_o), 32'h0F0);
    chk("R4 status no flag", 32'(status_o), 32'h250);
    fire(8'h10, 32'hA6, 9'h0AA, 4'h0, 2'd0, 1'b0);
    chk("R4 sw-correctable repeat flag", 32'(status_o), 32'h150);
    chk("R6 swc over hwc", addr_o, 32'hA6);
    chk("R8 dsyn swc", 32'(dsyn_o), 32'h0AA);
    clear(10'h100);
    chk("R4 flag cleared", 32'(status_o), 32'h050);
    clear(10'h000);
    chk("R2 zero write no effect", 32'(status_o), 32'h050);
  endtask

  task automatic t_collide();
    wr_en = 1'b1; wr_data = 10'h010;
    fire(8'h10, 32'hA7, 9'h111, 4'h0, 2'd0, 1'b0);
    wr_en = 1'b0; wr_data = '0;
    chk("R3 error wins over clear", 32'(status_o), 32'h050);
    chk("R3 owner kept", addr_o, 32'hA6);
  endtask

  task automatic t_beats();
    clear(10'h3FF);
    chk("R2 clear all", 32'(status_o), 32'h0);
    fire(8'h08, 32'hB1, 9'h111, 4'h9, 2'd0, 1'b0);
    chk("R8 tsyn type3", 32'(tsyn_o), 32'h9);
    chk("R8 dsyn not eligible", 32'(dsyn_o), 32'h0AA);
    fire(8'h04, 32'hB2, 9'h122, 4'h1, 2'd2, 1'b0);
    chk("R5 later beat ignored", 32'(status_o), 32'h008);
    chk("R5 addr untouched", addr_o, 32'hB1);
    fire(8'h08, 32'hB4, 9'h133, 4'h2, 2'd3, 1'b0);
    chk("R5 no flag from later beat", 32'(status_o), 32'h008);
    fire(8'h04, 32'hB3, 9'h1FF, 4'h4, 2'd0, 1'b0);
    chk("R5 new transfer accepted", 32'(status_o), 32'h00C);
    chk("R6 same class held", addr_o, 32'hB1);
    chk("R8 dsyn own lock", 32'(dsyn_o), 32'h1FF);
  endtask

  task automatic t_tie();
    clear(10'h3FF);
    fire(8'h0C, 32'hC1, 9'h0, 4'h5, 2'd0, 1'b0);
    chk("R6 tie capture", addr_o, 32'hC1);
    clear(10'h008);
    fire(8'h80, 32'hC2, 9'h0, 4'h6, 2'd0, 1'b0);
    chk("R6 lowest index owns tie", addr_o, 32'hC1);
    clear(10'h004);
    fire(8'h80, 32'hC3, 9'h0, 4'h7, 2'd0, 1'b0);
    chk("R7 release by owner bit", addr_o, 32'hC3);
    chk("R4 hwc repeat no flag", 32'(status_o[8]), 32'h0);
  endtask

  task automatic t_pin_trap();
    clear(10'h3FF);
    chk("R10 pin low", 32'(err_pin_o), 32'h0);
    fire(8'h02, 32'hD1, 9'h0, 4'h0, 2'd0, 1'b0);
    chk("R10 pin internal", 32'(err_pin_o), 32'h1);
    chk("R11 no trap for pin type", 32'(trap_req_o), 32'h0);
    clear(10'h002);
    chk("R10 pin drops", 32'(err_pin_o), 32'h0);
    fire(8'h01, 32'hD2, 9'h0, 4'h0, 2'd0, 1'b0);
    chk("R10 pin protocol", 32'(err_pin_o), 32'h1);
    fire(8'h80, 32'hD3, 9'h0, 4'h0, 2'd0, 1'b0);
    chk("R11 trap hwc", 32'(trap_req_o), 32'h1);
    irq_en = 1'b0; #1;
    chk("R11 trap gated", 32'(trap_req_o), 32'h0);
  endtask

  initial begin
    #22;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_capture();
    t_overwrite();
    t_unlock();
    t_collide();
    t_beats();
    t_tie();
    t_pin_trap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule